// File: doc/BRIEF.md
# External Interrupt Sense Unit

This unit watches four external request pins and turns pin activity into per-channel interrupt requests. Each channel has its own two-bit sense mode: low level, any toggle, falling edge or rising edge. Pins pass through a two-flop synchroniser and a sample register, and edges are found by comparing the two newest synchronised samples. Edge and toggle events set a pending flag for the channel. The flag is cleared by the channel's acknowledge pulse or by a write-one-to-clear access. Low-level requests are not latched. They follow the synchronised pin.

Software reaches the unit through a small register port with three addresses: a sense-control register, an enable-mask register and a pending register. A channel's request reaches the CPU side only while its mask bit and the global enable input are both 1. The pin is a plain input, so logic that drives the same net from the device side can raise an interrupt on purpose.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the control register, the mask register, every pending flag and `irq_req_o` read as zero.
- R2: The control register at address 0 is 8 bits, all readable and writable. Channel n takes its sense mode from bits [2n+1:2n]. The modes are 00 low level, 01 any change, 10 falling edge and 11 rising edge. A write takes effect on the next clock edge.
- R3: The mask register at address 1 keeps bits 3:0 as the enables of channels 3..0. Bits 7:4 always read as zero, whatever was written.
- R4: `irq_req_o[n]` is 1 only while mask bit n is 1 and `gie_i` is 1.
- R5: In low-level mode, the request is asserted two clock edges after the pin goes low. It drops two clock edges after the pin returns high, and it sets no pending flag.
- R6: In falling-edge mode, a high-to-low pin change sets the channel's pending flag on the third clock edge after the change. The flag then holds.
- R7: In rising-edge mode, only a low-to-high change sets the pending flag. A high-to-low change does not.
- R8: In any-change mode, both a falling and a rising pin change set the pending flag.
- R9: A one-cycle pulse on `irq_ack_i[n]` clears pending flag n. Writing 1 to bit n of the pending register (address 2) also clears it. Reading address 2 returns the pending flags in bits 3:0.
- R10: A pending flag is set even while its channel is masked or `gie_i` is 0. The flag shows on `irq_req_o` as soon as the channel is enabled.
- R11: Pins held high through reset produce no pending flag and no request after reset is released.
- R12: Changing a channel's sense bits while it is enabled is not filtered. For example, switching to low-level mode while the pin is low asserts the request on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | External request pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| bus_addr_i | input | 2 | Register address: 0 control, 1 mask, 2 pending |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_ack_i | input | 4 | Per-channel acknowledge pulse |
| irq_req_o | output | 4 | Per-channel interrupt request |

## Verification
A wrong pending flag shows on `irq_req_o` within one cycle of the channel being enabled, and it can be read at address 2 at any time. A wrongly clocked synchroniser or sample register moves the first request cycle away from the second edge (level mode) or the third edge (edge modes) after a pin change. The bench checks that exact cycle and the cycle before it. A mode decoded from the wrong control bits shows as a request on the wrong channel, or as a missing request, once the bench drives a single channel with a distinct mode.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW    = 2'b00,
        SENSE_TOGGLE = 2'b01,
        SENSE_FALL   = 2'b10,
        SENSE_RISE   = 2'b11
    } sense_e;

    localparam int REG_CTRL = 0;
    localparam int REG_MASK = 1;
    localparam int REG_PEND = 2;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int N    = 4,
    parameter int WARM = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o,
    output logic         valid_o
);
    localparam int WW = $clog2(WARM + 1);
    localparam logic [WW-1:0] WARM_END = WW'(WARM);

    typedef struct packed {
        logic [N-1:0]  s1;
        logic [N-1:0]  s2;
        logic [N-1:0]  smp;
        logic [WW-1:0] warm;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = pin_i;
        st_d.s2  = st_q.s1;
        st_d.smp = st_q.s2;
        if (st_q.warm != WARM_END) begin
            st_d.warm = st_q.warm + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o   = st_q.s2;
    assign prev_o  = st_q.smp;
    assign valid_o = (st_q.warm == WARM_END);

    // R11: once the sample path is primed it stays primed
    p_valid_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       valid_i,
    input  logic       cur_i,
    input  logic       prev_i,
    input  logic       clr_i,
    output logic       pend_o,
    output logic       raw_o
);
    typedef struct packed {
        logic pend;
    } st_t;

    st_t    st_d, st_q;
    sense_e mode;
    logic   evt;

    always_comb begin
        mode = sense_e'(mode_i);
        unique case (mode)
            SENSE_TOGGLE: evt = cur_i ^ prev_i;
            SENSE_FALL:   evt = prev_i & ~cur_i;
            SENSE_RISE:   evt = ~prev_i & cur_i;
            default:      evt = 1'b0;
        endcase
        evt = evt & valid_i;

        st_d = st_q;
        if (evt) begin
            st_d.pend = 1'b1;
        end else if (clr_i) begin
            st_d.pend = 1'b0;
        end

        if (mode == SENSE_LOW) begin
            raw_o = valid_i & ~cur_i;
        end else begin
            raw_o = st_q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // R6: a pending flag holds until cleared
    p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
    // R8: an enabled edge event always lands in the flag
    p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend_o);
    // R9: a clear with no competing event empties the flag
    p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt) |=> !pend_o);
    // R5: low-level mode never latches a high pin
    p_level_nolatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && cur_i) |-> !raw_o);

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_i,
    input  logic            wr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [N-1:0]    pend_i,
    output logic [DW-1:0]   rdata_o,
    output logic [2*N-1:0]  ctrl_o,
    output logic [N-1:0]    mask_o,
    output logic [N-1:0]    clr_o
);
    localparam int CW = 2 * N;
    localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);
    localparam logic [AW-1:0] A_MASK = AW'(REG_MASK);
    localparam logic [AW-1:0] A_PEND = AW'(REG_PEND);

    typedef struct packed {
        logic [CW-1:0] ctrl;
        logic [N-1:0]  mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (wr_i) begin
            if (addr_i == A_CTRL) st_d.ctrl = wdata_i[CW-1:0];
            if (addr_i == A_MASK) st_d.mask = wdata_i[N-1:0];
            if (addr_i == A_PEND) clr_o     = wdata_i[N-1:0];
        end

        if (addr_i == A_CTRL) begin
            rdata_o = DW'(st_q.ctrl);
        end else if (addr_i == A_MASK) begin
            rdata_o = DW'(st_q.mask);
        end else if (addr_i == A_PEND) begin
            rdata_o = DW'(pend_i);
        end else begin
            rdata_o = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign mask_o = st_q.mask;

    // R3: the unused upper part of the mask read is zero
    p_mask_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_MASK) |-> (rdata_o[DW-1:N] == '0));
    // R2: a control write is visible on the next cycle
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CTRL) |=> (ctrl_o == $past(wdata_i[CW-1:0])));

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pin_i,
    input  logic          gie_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic          bus_wr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic [N-1:0]  irq_ack_i,
    output logic [N-1:0]  irq_req_o
);
    logic [N-1:0]   cur, prev, pend, raw, mask, wclr;
    logic [2*N-1:0] ctrl;
    logic           valid;

    ext_irq_sync #(.N(N), .WARM(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .cur_o   (cur),
        .prev_o  (prev),
        .valid_o (valid)
    );

    ext_irq_regs #(.N(N), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .pend_i  (pend),
        .rdata_o (bus_rdata_o),
        .ctrl_o  (ctrl),
        .mask_o  (mask),
        .clr_o   (wclr)
    );

    for (genvar n = 0; n < N; n++) begin : g_ch
        ext_irq_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (ctrl[2*n+1:2*n]),
            .valid_i (valid),
            .cur_i   (cur[n]),
            .prev_i  (prev[n]),
            .clr_i   (irq_ack_i[n] | wclr[n]),
            .pend_o  (pend[n]),
            .raw_o   (raw[n])
        );

        assign irq_req_o[n] = raw[n] & mask[n] & gie_i;

        // R4: a request needs the channel enable
        p_req_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req_o[n] |-> mask[n]);
    end

    // R4: no request leaves while the global enable is off
    p_req_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> (irq_req_o == '0));

endmodule

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/1ps
module ext_irq_sense_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = 4'hF;
    logic       gie = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [3:0] ack = 4'h0;
    logic [3:0] req;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_sense uut (
        .clk (clk), .rst_n (rst_n), .pin_i (pin), .gie_i (gie),
        .bus_addr_i (addr), .bus_wr_i (wr), .bus_wdata_i (wdata),
        .bus_rdata_o (rdata), .irq_ack_i (ack), .irq_req_o (req)
    );

    task automatic check(string rq, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        pin = 4'hF;
        wreg(2'd1, 8'h00);
        tick(4);
        wreg(2'd2, 8'h0F);
        gie = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rreg(2'd0, d); check("R1 ctrl", d, 0);
        rreg(2'd1, d); check("R1 mask", d, 0);
        rreg(2'd2, d); check("R1 pend", d, 0);
        check("R1 req", req, 0);
        wreg(2'd0, 8'hFF);
        wreg(2'd1, 8'h0F);
        tick(4); #1;
        check("R11 no request after reset", req, 0);
        rreg(2'd2, d); check("R11 no pending after reset", d, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wreg(2'd0, 8'h5A);
        rreg(2'd0, d); check("R2 ctrl readback", d, 8'h5A);
        wreg(2'd1, 8'hF0);
        rreg(2'd1, d); check("R3 reserved mask bits", d, 8'h00);
        wreg(2'd1, 8'hFF);
        rreg(2'd1, d); check("R3 mask readback", d, 8'h0F);
    endtask

    task automatic t_fall();
        settle();
        wreg(2'd0, 8'h02);
        wreg(2'd1, 8'h0F);
        pin[0] = 1'b0;
        tick(2); #1; check("R6 not before third edge", req, 0);
        tick(1); #1; check("R6 falling sets ch0", req, 4'h1);
        pin[0] = 1'b1;
        tick(3); #1; check("R6 flag holds", req, 4'h1);
        ack = 4'h1; tick(1); ack = 4'h0; #1;
        check("R9 ack clears", req, 0);
    endtask

    task automatic t_rise();
        logic [7:0] d;
        settle();
        wreg(2'd0, 8'h0C);
        wreg(2'd1, 8'h0F);
        pin[1] = 1'b0;
        tick(4); #1; check("R7 falling ignored in rise mode", req, 0);
        pin[1] = 1'b1;
        tick(3); #1; check("R7 rising sets ch1", req, 4'h2);
        rreg(2'd2, d); check("R9 pending read", d, 8'h02);
        wreg(2'd2, 8'h02); #1;
        check("R9 write-one clears", req, 0);
    endtask

    task automatic t_toggle();
        settle();
        wreg(2'd0, 8'h10);
        wreg(2'd1, 8'h0F);
        pin[2] = 1'b0;
        tick(3); #1; check("R8 toggle on fall", req, 4'h4);
        ack = 4'h4; tick(1); ack = 4'h0;
        pin[2] = 1'b1;
        tick(1); #1; check("R8 cleared between", req, 0);
        tick(2); #1; check("R8 toggle on rise", req, 4'h4);
    endtask

    task automatic t_gating();
        logic [7:0] d;
        settle();
        wreg(2'd0, 8'h80);
        pin[3] = 1'b0;
        tick(4); #1; check("R10 masked: no request", req, 0);
        rreg(2'd2, d); check("R10 pending while masked", d, 8'h08);
        gie = 1'b0;
        wreg(2'd1, 8'h0F); #1;
        check("R4 global enable off", req, 0);
        gie = 1'b1; #1;
        check("R10 shows when enabled", req, 4'h8);
    endtask

    task automatic t_level();
        logic [7:0] d;
        settle();
        wreg(2'd0, 8'h00);
        wreg(2'd1, 8'h01);
        pin[0] = 1'b0;
        tick(1); #1; check("R5 not after one edge", req, 0);
        tick(1); #1; check("R5 low level requests", req, 4'h1);
        pin[0] = 1'b1;
        tick(1); #1; check("R5 still low in sync", req, 4'h1);
        tick(1); #1; check("R5 no latch", req, 0);
        rreg(2'd2, d); check("R5 no pending flag", d, 0);
    endtask

    task automatic t_modechg();
        settle();
        wreg(2'd0, 8'h02);
        wreg(2'd1, 8'h01);
        pin[0] = 1'b0;
        tick(3);
        ack = 4'h1; tick(1); ack = 4'h0;
        tick(2); #1; check("R12 quiet before change", req, 0);
        wreg(2'd0, 8'h00); #1;
        check("R12 request on mode change", req, 4'h1);
        pin[0] = 1'b1;
        tick(2); #1; check("R12 released", req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regs();
        t_fall();
        t_rise();
        t_toggle();
        t_gating();
        t_level();
        t_modechg();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule